// File: doc/BRIEF.md
# Condition-Gated Save/Restore Queue

This block serves one quadrant of a modulo-scheduled processing-element array. During an evaluator loop, a processing element can attach a push to another operation and so save a value. The value is not kept yet. It waits in a pending area, tagged with its iteration number, until the loop condition for that iteration resolves in a later stage. If the condition is true, every pending value of that iteration moves into the committed store, in the order the values were pushed. If the condition is false, the values are dropped. A value pushed with its keep-always flag set is committed whatever the condition is, for example a value on a loop-carried recurrence.

During the executor loop that follows, one processing element pops the committed values in commit order. The store is addressed by plain read and write counters. The block also counts the iterations whose condition was true, and that count is the trip count of the executor loop. A synchronous clear prepares the block for the next evaluator loop.

Top module: `cond_save_queue`

## Requirements
- R1: After reset, and in the cycle after a `clr`, `pop_vld`, `pop_unf`, `push_ovf` and `pop_data` are 0, `trip_count` is 0, and nothing is pending or committed.
- R2: A pushed value cannot be popped before its iteration has resolved. A pop in that window reports underflow.
- R3: A resolve with `res_true`=1 commits every pending value whose 4-bit tag equals `res_iter`, in push order. Values of other iterations stay pending and keep their relative order.
- R4: A resolve with `res_true`=0 discards the pending values of that iteration that do not have the keep-always flag set, so no pop ever returns them.
- R5: A value pushed with `push_always`=1 is committed when its iteration resolves, whether `res_true` is 0 or 1.
- R6: A push in the same cycle as the resolve of its own iteration takes part in that resolve, and it commits after that iteration's older values.
- R7: A pop request with committed data present returns the oldest committed value on `pop_data`, with `pop_vld`=1, in the next cycle. When there is no pop request, `pop_vld` and `pop_data` are 0 in the next cycle.
- R8: A pop request while the committed store is empty gives `pop_unf`=1, `pop_vld`=0 and `pop_data`=0 in the next cycle. A pop sees only values committed in earlier cycles.
- R9: A push is refused when `PEND_DEPTH` values are already pending, or when pending plus committed values already total `COM_DEPTH`. A refused push is dropped and raises `push_ovf` for one cycle in the next cycle. Pops and resolves in the same cycle do not free room for it.
- R10: `trip_count` increases by one in the cycle after each resolve with `res_true`=1, and does not change otherwise.
- R11: `clr` takes priority over every other input in its cycle. It empties the pending and committed storage and zeroes the trip count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear before a new evaluator loop |
| push_en | input | 1 | Push side-operation enable |
| push_data | input | DATA_W | Value to save |
| push_iter | input | ITER_W | Iteration tag of the pushed value |
| push_always | input | 1 | Commit this value whatever the condition |
| res_vld | input | 1 | Condition of one iteration resolves this cycle |
| res_iter | input | ITER_W | Iteration being resolved |
| res_true | input | 1 | Resolved condition value |
| pop_req | input | 1 | Pop request from the executor loop |
| pop_vld | output | 1 | Popped value present |
| pop_data | output | DATA_W | Popped value, 0 when none |
| pop_unf | output | 1 | Pop was attempted on an empty store |
| push_ovf | output | 1 | Previous-cycle push was refused |
| trip_count | output | TRIP_W | Number of true iterations so far |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a resolve moves values into the committed store while a pop reads from it. In the second pair, a push arrives together with the resolve of its own iteration. The bench provokes both: it pops from an empty store in the very cycle that a true resolve fills it, which must give underflow and leave the value for the next pop. It also issues pushes in the cycle their iteration resolves, then checks where they fall in the pop order. A behavioural model built on queues predicts every output on every clock and judges both cases.

// File: rtl/csq_pkg.sv
package csq_pkg;
  // bits needed to hold a count from 0 up to n inclusive
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/csq_pending.sv
module csq_pending
  import csq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ITER_W     = 4,
  parameter int PEND_DEPTH = 8,
  parameter int PCW        = count_width(PEND_DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_sn,
  input  logic                             clr,
  input  logic                             acc,
  input  logic [DATA_W-1:0]                in_data,
  input  logic [ITER_W-1:0]                in_iter,
  input  logic                             in_alw,
  input  logic                             res_vld,
  input  logic [ITER_W-1:0]                res_iter,
  input  logic                             res_true,
  output logic [PCW-1:0]                   pend_cnt,
  output logic [PCW-1:0]                   cm_cnt,
  output logic [PEND_DEPTH-1:0][DATA_W-1:0] cm_data
);
  logic [DATA_W-1:0] sd_q [PEND_DEPTH];
  logic [ITER_W-1:0] si_q [PEND_DEPTH];
  logic              sa_q [PEND_DEPTH];
  logic [DATA_W-1:0] sd_d [PEND_DEPTH];
  logic [ITER_W-1:0] si_d [PEND_DEPTH];
  logic              sa_d [PEND_DEPTH];
  logic [PCW-1:0]    pcnt_q, pcnt_d;

  // slots in push order, incoming push appended as the youngest
  logic [DATA_W-1:0] ed [PEND_DEPTH+1];
  logic [ITER_W-1:0] ei [PEND_DEPTH+1];
  logic              ea [PEND_DEPTH+1];
  logic              ev [PEND_DEPTH+1];

  always_comb begin
    for (int k = 0; k < PEND_DEPTH; k++) begin
      ed[k] = sd_q[k];
      ei[k] = si_q[k];
      ea[k] = sa_q[k];
      ev[k] = (k < int'(pcnt_q));
    end
    ed[PEND_DEPTH] = in_data;
    ei[PEND_DEPTH] = in_iter;
    ea[PEND_DEPTH] = in_alw;
    ev[PEND_DEPTH] = acc;
  end

  int  cpos, spos;
  logic hit;
  always_comb begin
    cpos    = 0;
    spos    = 0;
    hit     = 1'b0;
    cm_data = '0;
    for (int k = 0; k < PEND_DEPTH; k++) begin
      sd_d[k] = sd_q[k];
      si_d[k] = si_q[k];
      sa_d[k] = sa_q[k];
    end
    for (int k = 0; k <= PEND_DEPTH; k++) begin
      hit = ev[k] && res_vld && (ei[k] == res_iter);
      if (hit && (res_true || ea[k])) begin
        if (cpos < PEND_DEPTH) cm_data[cpos] = ed[k];
        cpos = cpos + 1;
      end else if (ev[k] && !hit) begin
        if (spos < PEND_DEPTH) begin
          sd_d[spos] = ed[k];
          si_d[spos] = ei[k];
          sa_d[spos] = ea[k];
        end
        spos = spos + 1;
      end
    end
    cm_cnt = PCW'(cpos);
    pcnt_d = PCW'(spos);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  pcnt_q <= '0;
    else if (clr) pcnt_q <= '0;
    else          pcnt_q <= pcnt_d;
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int k = 0; k < PEND_DEPTH; k++) begin
        sd_q[k] <= sd_d[k];
        si_q[k] <= si_d[k];
        sa_q[k] <= sa_d[k];
      end
    end
  end

  assign pend_cnt = pcnt_q;
endmodule

// File: rtl/csq_store.sv
module csq_store
  import csq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PEND_DEPTH = 8,
  parameter int COM_DEPTH  = 16,
  parameter int PCW        = count_width(PEND_DEPTH),
  parameter int CCW        = count_width(COM_DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_sn,
  input  logic                              clr,
  input  logic [PCW-1:0]                    cm_cnt,
  input  logic [PEND_DEPTH-1:0][DATA_W-1:0] cm_data,
  input  logic                              pop_req,
  output logic [CCW-1:0]                    com_cnt,
  output logic                              pop_vld,
  output logic [DATA_W-1:0]                 pop_data,
  output logic                              pop_unf
);
  localparam int AW = $clog2(COM_DEPTH);

  logic [DATA_W-1:0] mem [COM_DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CCW-1:0]    ccnt_q, ccnt_d;
  logic              pop_hit;

  always_comb begin
    pop_hit = pop_req && (ccnt_q != '0);
    wr_d    = wr_q + AW'(cm_cnt);
    rd_d    = rd_q + AW'(pop_hit);
    ccnt_d  = ccnt_q + CCW'(cm_cnt) - CCW'(pop_hit);
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int k = 0; k < PEND_DEPTH; k++) begin
        if (k < int'(cm_cnt)) mem[wr_q + AW'(k)] <= cm_data[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_q     <= '0;
      rd_q     <= '0;
      ccnt_q   <= '0;
      pop_vld  <= 1'b0;
      pop_data <= '0;
      pop_unf  <= 1'b0;
    end else if (clr) begin
      wr_q     <= '0;
      rd_q     <= '0;
      ccnt_q   <= '0;
      pop_vld  <= 1'b0;
      pop_data <= '0;
      pop_unf  <= 1'b0;
    end else begin
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      ccnt_q   <= ccnt_d;
      pop_vld  <= pop_hit;
      pop_data <= pop_hit ? mem[rd_q] : '0;
      pop_unf  <= pop_req && !pop_hit;
    end
  end

  assign com_cnt = ccnt_q;
endmodule

// File: rtl/csq_trip.sv
module csq_trip #(
  parameter int TRIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              clr,
  input  logic              inc,
  output logic [TRIP_W-1:0] count
);
  logic [TRIP_W-1:0] cnt_d;

  always_comb cnt_d = count + TRIP_W'(inc);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= cnt_d;
  end
endmodule

// File: rtl/cond_save_queue.sv
module cond_save_queue
  import csq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ITER_W     = 4,
  parameter int PEND_DEPTH = 8,
  parameter int COM_DEPTH  = 16,
  parameter int TRIP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ITER_W-1:0] push_iter,
  input  logic              push_always,
  input  logic              res_vld,
  input  logic [ITER_W-1:0] res_iter,
  input  logic              res_true,
  input  logic              pop_req,
  output logic              pop_vld,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_unf,
  output logic              push_ovf,
  output logic [TRIP_W-1:0] trip_count
);
  localparam int PCW = count_width(PEND_DEPTH);
  localparam int CCW = count_width(COM_DEPTH);

  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  logic [PCW-1:0]                    pend_cnt, cm_cnt;
  logic [CCW-1:0]                    com_cnt;
  logic [PEND_DEPTH-1:0][DATA_W-1:0] cm_data;
  logic                              ovf_now, acc;

  always_comb begin
    ovf_now = push_en && ((int'(pend_cnt) == PEND_DEPTH) ||
                          (int'(pend_cnt) + int'(com_cnt) >= COM_DEPTH));
    acc     = push_en && !ovf_now && !clr;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  push_ovf <= 1'b0;
    else if (clr) push_ovf <= 1'b0;
    else          push_ovf <= ovf_now;
  end

  csq_pending #(.DATA_W(DATA_W), .ITER_W(ITER_W), .PEND_DEPTH(PEND_DEPTH)) i_pend (
    .clk(clk), .rst_sn(rst_sn), .clr(clr), .acc(acc),
    .in_data(push_data), .in_iter(push_iter), .in_alw(push_always),
    .res_vld(res_vld), .res_iter(res_iter), .res_true(res_true),
    .pend_cnt(pend_cnt), .cm_cnt(cm_cnt), .cm_data(cm_data)
  );

  csq_store #(.DATA_W(DATA_W), .PEND_DEPTH(PEND_DEPTH), .COM_DEPTH(COM_DEPTH)) i_store (
    .clk(clk), .rst_sn(rst_sn), .clr(clr), .cm_cnt(cm_cnt), .cm_data(cm_data),
    .pop_req(pop_req), .com_cnt(com_cnt), .pop_vld(pop_vld),
    .pop_data(pop_data), .pop_unf(pop_unf)
  );

  csq_trip #(.TRIP_W(TRIP_W)) i_trip (
    .clk(clk), .rst_sn(rst_sn), .clr(clr),
    .inc(res_vld && res_true && !clr), .count(trip_count)
  );
endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
  parameter int DATA_W = 16,
  parameter int TRIP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              push_en,
  input logic              pop_req,
  input logic              res_vld,
  input logic              res_true,
  input logic              pop_vld,
  input logic [DATA_W-1:0] pop_data,
  input logic              pop_unf,
  input logic              push_ovf,
  input logic [TRIP_W-1:0] trip_count
);
  // R8
  unf_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_unf |-> (!pop_vld && pop_data == '0));

  // R7
  pop_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pop_req) |-> (!pop_vld && !pop_unf && pop_data == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf |-> $past(push_en));

  // R10
  trip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_vld && res_true) && !$past(clr)) |-> (trip_count == $past(trip_count) + TRIP_W'(1)));

  // R10
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(res_vld && res_true) && !$past(clr)) |-> $stable(trip_count));

  // R11
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (trip_count == '0 && !pop_vld && !pop_unf && !push_ovf));
endmodule

bind cond_save_queue csq_checker #(.DATA_W(DATA_W), .TRIP_W(TRIP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .push_en(push_en), .pop_req(pop_req),
  .res_vld(res_vld), .res_true(res_true), .pop_vld(pop_vld), .pop_data(pop_data),
  .pop_unf(pop_unf), .push_ovf(push_ovf), .trip_count(trip_count)
);

// File: tb/test_cond_save_queue.sv
module test_cond_save_queue;
  localparam int DW = 16, IW = 4, PD = 8, CD = 16, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic push_en = 1'b0, push_always = 1'b0, res_vld = 1'b0, res_true = 1'b0, pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [IW-1:0] push_iter = '0, res_iter = '0;
  logic pop_vld, pop_unf, push_ovf;
  logic [DW-1:0] pop_data;
  logic [TW-1:0] trip_count;

  always #5 clk = ~clk;

  cond_save_queue #(.DATA_W(DW), .ITER_W(IW), .PEND_DEPTH(PD), .COM_DEPTH(CD), .TRIP_W(TW)) i_cond_save_queue (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_en(push_en), .push_data(push_data),
    .push_iter(push_iter), .push_always(push_always), .res_vld(res_vld), .res_iter(res_iter),
    .res_true(res_true), .pop_req(pop_req), .pop_vld(pop_vld), .pop_data(pop_data),
    .pop_unf(pop_unf), .push_ovf(push_ovf), .trip_count(trip_count)
  );

  typedef struct { logic [DW-1:0] d; int it; bit a; } ent_t;
  ent_t pend[$];
  logic [DW-1:0] com[$];
  int trip = 0;
  int errors = 0, checks = 0;
  bit x_vld, x_unf, x_ovf;
  logic [DW-1:0] x_data;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one clock: drive, step model, compare after the edge
  task automatic cyc(input bit pe, input int pd, input int pi, input bit pa,
                     input bit rv, input int ri, input bit rt, input bit pp,
                     input bit cl, input string tag);
    ent_t keep[$];
    push_en = pe; push_data = DW'(pd); push_iter = IW'(pi); push_always = pa;
    res_vld = rv; res_iter = IW'(ri); res_true = rt; pop_req = pp; clr = cl;
    if (cl) begin
      pend.delete(); com.delete(); trip = 0;
      x_vld = 0; x_unf = 0; x_ovf = 0; x_data = '0;
    end else begin
      x_ovf = pe && (pend.size() == PD || pend.size() + com.size() >= CD);
      x_vld = 0; x_unf = 0; x_data = '0;
      if (pp) begin
        if (com.size() > 0) begin x_vld = 1; x_data = com.pop_front(); end
        else x_unf = 1;
      end
      if (pe && !x_ovf) pend.push_back('{d: DW'(pd), it: pi % 16, a: pa});
      if (rv) begin
        foreach (pend[k]) begin
          if (pend[k].it == ri % 16) begin
            if (rt || pend[k].a) com.push_back(pend[k].d);
          end else keep.push_back(pend[k]);
        end
        pend = keep;
        if (rt) trip++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(pop_vld == x_vld, tag, "pop_vld", int'(pop_vld), int'(x_vld));
    check(pop_data == x_data, tag, "pop_data", int'(pop_data), int'(x_data));
    check(pop_unf == x_unf, tag, "pop_unf", int'(pop_unf), int'(x_unf));
    check(push_ovf == x_ovf, tag, "push_ovf", int'(push_ovf), int'(x_ovf));
    check(int'(trip_count) == trip, tag, "trip_count", int'(trip_count), trip);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic push(input int d, input int it, input bit a, input string tag);
    cyc(1, d, it, a, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic resolve(input int it, input bit t, input string tag);
    cyc(0, 0, 0, 0, 1, it, t, 0, 0, tag);
  endtask
  task automatic pop(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1-timeout actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs after reset
    idle(4, "R1");

    // R2: pending value not poppable before resolve
    push(16'h0101, 0, 0, "R2");
    pop("R2");
    // R3: interleaved iterations; iteration 0 commits first, in push order
    push(16'h0111, 1, 0, "R3");
    push(16'h0102, 0, 0, "R3");
    push(16'h0112, 1, 0, "R3");
    resolve(0, 1, "R3");
    resolve(1, 1, "R3");
    for (int k = 0; k < 4; k++) pop("R3");
    // R4 and R5: false resolve drops all but the keep-always value
    push(16'h0201, 2, 0, "R4");
    push(16'h0202, 2, 1, "R5");
    push(16'h0203, 2, 0, "R4");
    resolve(2, 0, "R4");
    pop("R5");
    pop("R4");
    // R6: push in the resolve cycle of its own iteration
    push(16'h0301, 3, 0, "R6");
    cyc(1, 16'h0302, 3, 0, 1, 3, 1, 0, 0, "R6");
    cyc(1, 16'h0303, 4, 0, 1, 4, 0, 0, 0, "R6");
    pop("R6"); pop("R6"); pop("R6");
    // R8: pop on empty in the same cycle a resolve commits
    push(16'h0401, 5, 0, "R8");
    cyc(0, 0, 0, 0, 1, 5, 1, 1, 0, "R8");
    pop("R8");
    pop("R8");
    // R9: pending full
    for (int k = 0; k < PD; k++) push(16'h0500 + k, 6, 0, "R9");
    push(16'h05FF, 7, 0, "R9");
    resolve(7, 1, "R9");
    pop("R9");
    resolve(6, 0, "R9");
    // R9: committed plus pending full, pop in same cycle does not help
    for (int k = 0; k < CD; k++) cyc(1, 16'h0600 + k, 8, 0, 1, 8, 1, 0, 0, "R9");
    cyc(1, 16'h06FF, 9, 0, 0, 0, 0, 1, 0, "R9");
    push(16'h0700, 9, 1, "R9");
    resolve(9, 0, "R9");
    // R7: drain in commit order, with back-to-back pops and gaps
    for (int k = 0; k < CD; k++) begin
      pop("R7");
      if (k % 5 == 0) idle(1, "R7");
    end
    pop("R8");
    // R10: trip count steps
    resolve(10, 1, "R10");
    resolve(11, 0, "R10");
    resolve(12, 1, "R10");
    // R11: clear overrides a push, resolve and pop in its cycle
    push(16'h0801, 13, 0, "R11");
    resolve(13, 1, "R11");
    push(16'h0802, 14, 0, "R11");
    cyc(1, 16'h0803, 14, 1, 1, 14, 1, 1, 1, "R11");
    pop("R11");
    resolve(14, 1, "R11");
    pop("R11");
    idle(2, "R1");
    summary();
    $finish;
  end
endmodule